// File: doc/BRIEF.md
# Store Queue Write-Back Address Translator

This block turns the virtual address of a store-queue write-back into the external bus address the burst will use. Only addresses whose top six bits read `111000` (the 64 MB window starting at 0xE0000000) are legal. When address translation is off, the address is built directly. Address bit 5 picks one of two 3-bit area fields, which become bits 28:26. Virtual bits 25:5 are copied through, and the low five bits are cleared so the result is aligned to a 32-byte line.

When translation is on, the block sends the virtual address out on a lookup port and waits for the response. It then applies the page permission checks for a store-queue write-back to the physical address it gets back. Those checks cover the privilege bit, the write-enable bit and the dirty bit. The result is a line-aligned address and a 3-bit error code.

Error codes: 0 none, 1 address error, 2 lookup miss, 3 lookup multi-hit, 4 protection violation, 5 first-write. Lookup status codes on `lk_status_i`: 0 hit, 1 miss, 2 multi-hit. Page permission `lk_perm_i[1]` set means user mode may access the page; `lk_perm_i[0]` set means the page is writable.

Top module: `sq_addr_xlat`

## Requirements
- R1: While `rst_ni` is low and after its release, `res_valid_o` and `lk_req_o` are 0 until a request arrives.
- R2: A request whose `req_va_i[31:26]` is not `6'b111000` completes with error code 1 and address 0 one cycle after the request, and issues no lookup.
- R3: A request with `req_va_i[1:0]` nonzero completes with error code 1 and address 0 one cycle after the request.
- R4: With `sqmd_i`=1 a request made with `priv_i`=0 completes with error code 1. A request made with `priv_i`=1 is not affected by `sqmd_i`.
- R5: With `at_en_i`=0 a legal request completes one cycle later with code 0 and address `(area<<26) | (va & 32'h03FFFFE0)`. The area is `area1_i` when va bit 5 is 1 and `area0_i` when it is 0.
- R6: With `at_en_i`=1 a legal request raises `lk_req_o` for exactly one cycle, one cycle after the request, with `lk_va_o` equal to the request address. The result appears one cycle after `lk_rsp_valid_i`, and on success it is `lk_pa_i` with bits 4:0 cleared.
- R7: A lookup status of miss or multi-hit yields error code 2 or 3, ahead of any permission check.
- R8: After a lookup hit, a request made in user mode (`priv_i`=0) to a page with `lk_perm_i[1]`=0 yields error code 4. A privileged request is not blocked by that bit.
- R9: After a lookup hit, a write (`req_write_i`=1) to a page with `lk_perm_i[0]`=0 yields code 4. A write to a page with `lk_perm_i[0]`=1 and `lk_dirty_i`=0 yields code 5. A read is subject to neither check. The privilege check of R8 takes precedence over both.
- R10: Requests arriving while a lookup is outstanding, and lookup responses arriving while none is outstanding, are ignored and produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Translation request strobe |
| req_va_i | input | 32 | Virtual address of the write-back |
| req_write_i | input | 1 | Access is a write |
| at_en_i | input | 1 | Address translation enabled |
| sqmd_i | input | 1 | Store queue restricted to privileged mode |
| priv_i | input | 1 | Core is in privileged mode |
| area0_i | input | 3 | Area field used when va bit 5 is 0 |
| area1_i | input | 3 | Area field used when va bit 5 is 1 |
| lk_req_o | output | 1 | Lookup request pulse |
| lk_va_o | output | 32 | Address sent for lookup |
| lk_rsp_valid_i | input | 1 | Lookup response strobe |
| lk_status_i | input | 2 | Lookup status: 0 hit, 1 miss, 2 multi-hit |
| lk_pa_i | input | 32 | Translated physical address |
| lk_perm_i | input | 2 | Page permission: bit 1 user access, bit 0 writable |
| lk_dirty_i | input | 1 | Page dirty bit |
| res_valid_o | output | 1 | Result strobe |
| res_addr_o | output | 32 | Line-aligned target address, 0 on error |
| res_err_o | output | 3 | Error code |

## Verification
The hardest situation to reach is a request or a response that lands at the wrong moment around an outstanding lookup. The bench holds the lookup response back for several cycles and, during that wait, issues a second request that must leave no trace. Once the first result has been delivered, it drives a lookup response with nothing pending. The response is also sent in the same cycle the lookup pulse is visible, so the zero-latency corner of the wait state is covered. The behavioural model, compared every clock, exposes any extra or missing result.

// File: rtl/sqx_pkg.sv
package sqx_pkg;
  typedef enum logic [2:0] {
    SQX_OK    = 3'd0,
    SQX_ADDR  = 3'd1,
    SQX_MISS  = 3'd2,
    SQX_MULTI = 3'd3,
    SQX_PROT  = 3'd4,
    SQX_FW    = 3'd5
  } sqx_err_e;

  typedef enum logic [1:0] {
    LK_HIT   = 2'd0,
    LK_MISS  = 2'd1,
    LK_MULTI = 2'd2
  } lk_status_e;
endpackage

// File: rtl/sqx_precheck.sv
module sqx_precheck #(
  parameter int AW     = 32,
  parameter int WIN_W  = 6,
  parameter logic [WIN_W-1:0] WIN_TAG = 6'b111000,
  parameter int ALIGN_W = 2
) (
  input  logic [AW-1:0] va_i,
  input  logic          sqmd_i,
  input  logic          priv_i,
  output logic          addr_err_o
);
  logic out_of_window, misaligned, user_blocked;

  always_comb begin
    out_of_window = va_i[AW-1 -: WIN_W] != WIN_TAG;
    misaligned    = |va_i[ALIGN_W-1:0];
    user_blocked  = sqmd_i && !priv_i;
    addr_err_o    = out_of_window || misaligned || user_blocked;
  end
endmodule

// File: rtl/sqx_area_map.sv
module sqx_area_map #(
  parameter int AW        = 32,
  parameter int AREA_W    = 3,
  parameter int LINE_BITS = 5,
  parameter int WIN_W     = 6
) (
  input  logic [AW-1:0]     va_i,
  input  logic [AREA_W-1:0] area0_i,
  input  logic [AREA_W-1:0] area1_i,
  output logic [AW-1:0]     pa_o
);
  localparam int AREA_LSB = AW - WIN_W;

  logic [AREA_W-1:0] area;

  always_comb begin
    // the bit just above the line offset selects the queue
    area = va_i[LINE_BITS] ? area1_i : area0_i;
    pa_o = '0;
    pa_o[AREA_LSB +: AREA_W]        = area;
    pa_o[AREA_LSB-1:LINE_BITS]      = va_i[AREA_LSB-1:LINE_BITS];
  end
endmodule

// File: rtl/sqx_perm_check.sv
module sqx_perm_check
  import sqx_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LINE_BITS = 5
) (
  input  logic [1:0]    status_i,
  input  logic [AW-1:0] pa_i,
  input  logic [1:0]    perm_i,
  input  logic          dirty_i,
  input  logic          priv_i,
  input  logic          write_i,
  output sqx_err_e      err_o,
  output logic [AW-1:0] addr_o
);
  always_comb begin
    if (status_i == LK_MISS)                  err_o = SQX_MISS;
    else if (status_i != LK_HIT)              err_o = SQX_MULTI;
    else if (!priv_i && !perm_i[1])           err_o = SQX_PROT;
    else if (write_i && !perm_i[0])           err_o = SQX_PROT;
    else if (write_i && !dirty_i)             err_o = SQX_FW;
    else                                      err_o = SQX_OK;

    addr_o = '0;
    if (err_o == SQX_OK) addr_o = {pa_i[AW-1:LINE_BITS], {LINE_BITS{1'b0}}};
  end
endmodule

// File: rtl/sq_addr_xlat.sv
module sq_addr_xlat
  import sqx_pkg::*;
#(
  parameter int AW        = 32,
  parameter int AREA_W    = 3,
  parameter int LINE_BITS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [AW-1:0]     req_va_i,
  input  logic              req_write_i,
  input  logic              at_en_i,
  input  logic              sqmd_i,
  input  logic              priv_i,
  input  logic [AREA_W-1:0] area0_i,
  input  logic [AREA_W-1:0] area1_i,
  output logic              lk_req_o,
  output logic [AW-1:0]     lk_va_o,
  input  logic              lk_rsp_valid_i,
  input  logic [1:0]        lk_status_i,
  input  logic [AW-1:0]     lk_pa_i,
  input  logic [1:0]        lk_perm_i,
  input  logic              lk_dirty_i,
  output logic              res_valid_o,
  output logic [AW-1:0]     res_addr_o,
  output logic [2:0]        res_err_o
);
  localparam int WIN_W = 6;

  logic          addr_err;
  logic [AW-1:0] direct_pa, perm_addr;
  sqx_err_e      perm_err;

  logic          wait_q, write_q, priv_q, lk_req_q, res_valid_q;
  logic [AW-1:0] lk_va_q, res_addr_q;
  sqx_err_e      res_err_q;

  sqx_precheck #(.AW(AW), .WIN_W(WIN_W)) u_pre (
    .va_i(req_va_i), .sqmd_i(sqmd_i), .priv_i(priv_i), .addr_err_o(addr_err)
  );

  sqx_area_map #(.AW(AW), .AREA_W(AREA_W), .LINE_BITS(LINE_BITS), .WIN_W(WIN_W)) u_map (
    .va_i(req_va_i), .area0_i(area0_i), .area1_i(area1_i), .pa_o(direct_pa)
  );

  // permission uses the mode captured with the request
  sqx_perm_check #(.AW(AW), .LINE_BITS(LINE_BITS)) u_perm (
    .status_i(lk_status_i), .pa_i(lk_pa_i), .perm_i(lk_perm_i), .dirty_i(lk_dirty_i),
    .priv_i(priv_q), .write_i(write_q), .err_o(perm_err), .addr_o(perm_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q      <= 1'b0;
      write_q     <= 1'b0;
      priv_q      <= 1'b0;
      lk_req_q    <= 1'b0;
      lk_va_q     <= '0;
      res_valid_q <= 1'b0;
      res_addr_q  <= '0;
      res_err_q   <= SQX_OK;
    end else begin
      lk_req_q    <= 1'b0;
      res_valid_q <= 1'b0;
      if (!wait_q && req_valid_i) begin
        if (addr_err) begin
          res_valid_q <= 1'b1;
          res_err_q   <= SQX_ADDR;
          res_addr_q  <= '0;
        end else if (!at_en_i) begin
          res_valid_q <= 1'b1;
          res_err_q   <= SQX_OK;
          res_addr_q  <= direct_pa;
        end else begin
          wait_q   <= 1'b1;
          lk_req_q <= 1'b1;
          lk_va_q  <= req_va_i;
          write_q  <= req_write_i;
          priv_q   <= priv_i;
        end
      end else if (wait_q && lk_rsp_valid_i) begin
        wait_q      <= 1'b0;
        res_valid_q <= 1'b1;
        res_err_q   <= perm_err;
        res_addr_q  <= perm_addr;
      end
    end
  end

  assign lk_req_o    = lk_req_q;
  assign lk_va_o     = lk_va_q;
  assign res_valid_o = res_valid_q;
  assign res_addr_o  = res_addr_q;
  assign res_err_o   = res_err_q;

  a_r1_idle_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !res_valid_o && !lk_req_o);

  a_r2_window_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !wait_q && req_va_i[AW-1 -: WIN_W] != 6'b111000
      |=> res_valid_o && res_err_o == 3'd1 && !lk_req_o);

  a_r3_misaligned_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !wait_q && req_va_i[1:0] != 2'b00 |=> res_valid_o && res_err_o == 3'd1);

  a_r5_line_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_err_o == 3'd0 |-> res_addr_o[LINE_BITS-1:0] == '0);

  a_r6_lookup_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_o |=> !lk_req_o);

  a_r6_no_result_with_lookup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_o |-> !res_valid_o);

  a_r7_miss_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q && lk_rsp_valid_i && lk_status_i == 2'd1 |=> res_valid_o && res_err_o == 3'd2);

  a_r10_ignore_while_waiting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q && !lk_rsp_valid_i |=> !res_valid_o && !lk_req_o);
endmodule

// File: tb/sq_addr_xlat_test.sv
`timescale 1ns/1ps
module sq_addr_xlat_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, at_en = 0, sqmd = 0, priv = 1;
  logic [31:0] req_va = 0;
  logic [2:0]  area0 = 3'd2, area1 = 3'd5;
  logic        lk_req;
  logic [31:0] lk_va;
  logic        rsp_valid = 0, dirty = 0;
  logic [1:0]  status = 0, perm = 0;
  logic [31:0] pa = 0;
  logic        res_valid;
  logic [31:0] res_addr;
  logic [2:0]  res_err;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  sq_addr_xlat uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_va_i(req_va),
    .req_write_i(req_write), .at_en_i(at_en), .sqmd_i(sqmd), .priv_i(priv),
    .area0_i(area0), .area1_i(area1), .lk_req_o(lk_req), .lk_va_o(lk_va),
    .lk_rsp_valid_i(rsp_valid), .lk_status_i(status), .lk_pa_i(pa),
    .lk_perm_i(perm), .lk_dirty_i(dirty), .res_valid_o(res_valid),
    .res_addr_o(res_addr), .res_err_o(res_err)
  );

  // behavioural reference
  bit          m_wait, m_write, m_priv, m_lk, m_rv;
  logic [31:0] m_lkva, m_ra;
  int          m_re;

  function automatic int early_err(logic [31:0] va, bit sq, bit pv);
    if ((va >> 26) != 32'h38) return 1;
    if (va % 4 != 0) return 1;
    if (sq && !pv) return 1;
    return 0;
  endfunction

  function automatic int lookup_err(int st, logic [1:0] pr, bit d, bit pv, bit wr);
    if (st == 1) return 2;
    if (st == 2) return 3;
    if (!pv && !pr[1]) return 4;
    if (wr && !pr[0]) return 4;
    if (wr && !d) return 5;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wait = 0; m_lk = 0; m_rv = 0; m_ra = 0; m_re = 0; m_lkva = 0;
    end else begin
      m_lk = 0; m_rv = 0;
      if (!m_wait && req_valid) begin
        if (early_err(req_va, sqmd, priv) != 0) begin
          m_rv = 1; m_re = 1; m_ra = 0;
        end else if (!at_en) begin
          m_rv = 1; m_re = 0;
          m_ra = ((req_va[5] ? 32'(area1) : 32'(area0)) << 26) | (req_va & 32'h03FFFFE0);
        end else begin
          m_wait = 1; m_lk = 1; m_lkva = req_va; m_write = req_write; m_priv = priv;
        end
      end else if (m_wait && rsp_valid) begin
        m_wait = 0; m_rv = 1;
        m_re = lookup_err(int'(status), perm, dirty, m_priv, m_write);
        m_ra = (m_re == 0) ? (pa & ~32'h1F) : 32'h0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (res_valid !== m_rv || lk_req !== m_lk ||
          (m_rv && (res_addr !== m_ra || int'(res_err) != m_re)) ||
          (m_lk && lk_va !== m_lkva)) begin
        failures++;
        $display("FAIL %s: valid=%0b addr=%h err=%0d lk=%0b lkva=%h expected valid=%0b addr=%h err=%0d lk=%0b lkva=%h",
                 tag, res_valid, res_addr, res_err, lk_req, lk_va, m_rv, m_ra, m_re, m_lk, m_lkva);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      finish_run();
    end
  end

  task automatic send(logic [31:0] va, bit wr, bit at, bit sq, bit pv);
    req_va = va; req_write = wr; at_en = at; sqmd = sq; priv = pv; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic respond(int dly, int st, logic [31:0] p, logic [1:0] pr, bit d);
    repeat (dly) @(negedge clk);
    status = st[1:0]; pa = p; perm = pr; dirty = d; rsp_valid = 1;
    @(negedge clk);
    rsp_valid = 0;
  endtask

  task automatic xlat(logic [31:0] va, bit wr, bit pv, int dly, int st,
                      logic [31:0] p, logic [1:0] pr, bit d);
    send(va, wr, 1, 0, pv);
    respond(dly, st, p, pr, d);
    idle(2);
  endtask

  initial begin
    tag = "R1";
    idle(2);
    checks++;
    if (res_valid !== 0 || lk_req !== 0) begin
      failures++;
      $display("FAIL R1: valid=%0b lk=%0b expected 0 0", res_valid, lk_req);
    end
    rst_n = 1;
    idle(3);

    tag = "R5";
    send(32'hE000_0020, 1, 0, 0, 1); idle(2);
    send(32'hE3FF_FFC4, 1, 0, 0, 1); idle(2);
    area0 = 3'd7; area1 = 3'd0;
    send(32'hE155_5560, 0, 0, 0, 0); idle(2);
    send(32'hE155_5540, 0, 0, 0, 1); idle(2);

    tag = "R2";
    send(32'hE400_0000, 1, 1, 0, 1); idle(2);
    send(32'h6000_0000, 1, 0, 0, 1); idle(2);
    send(32'hDFFF_FFE0, 1, 1, 0, 1); idle(2);

    tag = "R3";
    send(32'hE000_0002, 1, 0, 0, 1); idle(2);
    send(32'hE000_0041, 1, 1, 0, 1); idle(2);

    tag = "R4";
    send(32'hE000_0100, 1, 0, 1, 0); idle(2);
    send(32'hE000_0100, 1, 0, 1, 1); idle(2);
    send(32'hE000_0100, 1, 0, 0, 0); idle(2);

    tag = "R6";
    xlat(32'hE000_1234 & ~32'h3, 1, 1, 0, 0, 32'h0C00_1234, 2'b11, 1);
    xlat(32'hE2AB_CDE0, 1, 1, 3, 0, 32'hFFFF_FFFF, 2'b11, 1);

    tag = "R7";
    xlat(32'hE000_0200, 1, 0, 1, 1, 32'h1000_0000, 2'b00, 0);
    xlat(32'hE000_0200, 1, 0, 0, 2, 32'h1000_0000, 2'b00, 0);

    tag = "R8";
    xlat(32'hE000_0300, 0, 0, 1, 0, 32'h2000_0040, 2'b01, 1);
    xlat(32'hE000_0300, 0, 1, 1, 0, 32'h2000_0040, 2'b00, 0);
    xlat(32'hE000_0300, 1, 0, 0, 0, 32'h2000_0040, 2'b00, 0);

    tag = "R9";
    xlat(32'hE000_0400, 1, 1, 0, 0, 32'h3000_0080, 2'b10, 1);
    xlat(32'hE000_0400, 1, 1, 2, 0, 32'h3000_0080, 2'b11, 0);
    xlat(32'hE000_0400, 0, 1, 0, 0, 32'h3000_0080, 2'b10, 0);
    xlat(32'hE000_0400, 1, 0, 0, 0, 32'h3000_009F, 2'b11, 1);

    tag = "R10";
    send(32'hE000_0500, 1, 1, 0, 1);
    send(32'hE000_0520, 1, 0, 0, 1);
    send(32'hE000_0003, 1, 0, 0, 1);
    respond(1, 0, 32'h4000_0100, 2'b11, 1);
    idle(2);
    respond(0, 0, 32'h5000_0000, 2'b11, 1);
    idle(3);

    finish_run();
  end
endmodule